// File: doc/BRIEF.md
# PCI DMA Address Window Translator

This block maps addresses that a PCI bus master drives for DMA onto system memory. Software programs four windows. Each window has a base, a size mask and a translated base, and one control register covers the whole block. Each request carries a bus address and a flag that marks it as a single-address (32-bit) or dual-address (64-bit) cycle.

The response arrives one clock later and reports one of three outcomes:
- a miss;
- a direct-mapped hit with the physical address;
- a scatter-gather hit with the address of the 8-byte page-table entry to fetch.

The entry fetch is done by the logic outside this block.

The highest-numbered window always works in scatter-gather mode. With its own enables it also serves as the only path for dual-address cycles. A control bit turns on a pass-through path ahead of the windows. In that path, single-address cycles below 2 GiB map one-to-one onto memory.

Top module: `dma_window_xlat`

## Requirements
- R1: After reset `rsp_valid`, `rsp_hit` and `rsp_sg` are 0. Window 3 holds base value 2: scatter-gather set, enable clear. All other windows and the control register are zero, so every request misses.
- R2: The write select `wr_sel` decodes as follows. `wr_sel[3:2]` is the kind: 0 base, 1 size mask, 2 translated base, 3 control. `wr_sel[1:0]` is the window. A base write to windows 0 to 2 keeps only data bits 31:20 (base), bit 1 (scatter-gather) and bit 0 (enable); all other bits are dropped.
- R3: A base write to window 3 keeps bits 39, 31:20 and 0. Bit 1 always reads as set, whatever was written.
- R4: A size-mask write keeps only bits 31:20. A translated-base write keeps only bits 34:10.
- R5: A single-address cycle uses `req_addr[31:0]`. A window matches when it is enabled and `addr[31:20]`, with the size-mask bits cleared, equals its base bits 31:20. Windows are tried in the order 0, 1, 2, 3, and the lowest match wins.
- R6: On a direct-mapped hit, `rsp_phys` is the translated base ORed with the address ANDed with {mask[31:20], 20 ones}. `rsp_pte` is 0.
- R7: On a scatter-gather hit, `rsp_pte` is the translated base plus 8 times bits 31:13 of that masked offset. `rsp_phys` is 0.
- R8: Window 3 takes part in single-address cycles only while its base bit 39 is clear.
- R9: A dual-address cycle hits only when all three of these bits are set: control bit 6, window 3 base bit 0 and window 3 base bit 39. `rsp_pte` is then (translated base bits 34:22) plus 8 times `req_addr[34:13]`, with `rsp_sg` set.
- R10: With control bit 5 set, a single-address cycle whose bit 31 is clear hits before any window. It returns `rsp_phys` equal to `addr[30:0]`, with `rsp_sg` clear.
- R11: On a miss, `rsp_hit` and `rsp_sg` are 0 and both address outputs are zero.
- R12: `rsp_valid` follows `req_valid` by one clock. A register write in the same cycle as a request does not affect that request's result.
- R13: A control write keeps only data bits 5 and 6; other bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select: kind in 3:2, window in 1:0 |
| wr_data | input | 40 | Write data |
| req_valid | input | 1 | Translation request |
| req_dac | input | 1 | 1 = dual-address cycle, 0 = single-address cycle |
| req_addr | input | 64 | PCI bus address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_sg | output | 1 | Result is a page-table entry address |
| rsp_phys | output | 35 | Direct physical address |
| rsp_pte | output | 35 | Page-table entry address |

## Verification
Two things can land on the same clock edge: a register write and a translation request. The bench sets up a scatter-gather window and then issues a request to it while, in the same cycle, writing zero to that window's base. The first response must still show the old mapping, and the request that follows must miss. A second overlap occurs inside the lookup: the pass-through path and a window both claim one address, and several windows cover the same range. These are judged by the result coming from the path of highest priority.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
  localparam int N_WIN      = 4;
  localparam int WIN_IDX_W  = 2;
  localparam int BUS_W      = 64;
  localparam int SAC_W      = 32;
  localparam int DATA_W     = 40;
  localparam int PA_W       = 35;
  localparam int WIN_LSB    = 20;
  localparam int WIN_HI_W   = SAC_W - WIN_LSB;
  localparam int TBA_LSB    = 10;
  localparam int TBA_W      = PA_W - TBA_LSB;
  localparam int PAGE_LSB   = 13;
  localparam int PTE_LSB    = 3;
  localparam int DAC_BIT    = 39;
  localparam int DAC_BASE_LSB = 22;
  localparam int CTL_PASS_BIT = 5;
  localparam int CTL_DAC_BIT  = 6;

  typedef enum logic [1:0] {
    KIND_BASE = 2'd0,
    KIND_MASK = 2'd1,
    KIND_TBA  = 2'd2,
    KIND_CTL  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic                en;
    logic                sg;
    logic                dac;
    logic [WIN_HI_W-1:0] base;
    logic [WIN_HI_W-1:0] mask;
    logic [TBA_W-1:0]    tba;
  } win_t;

  typedef struct packed {
    logic            hit;
    logic            sg;
    logic [PA_W-1:0] phys;
    logic [PA_W-1:0] pte;
  } xlat_t;
endpackage

// File: rtl/dwx_regs.sv
module dwx_regs
  import dwx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [3:0]           wr_sel,
  input  logic [DATA_W-1:0]    wr_data,
  output win_t                 win [N_WIN],
  output logic                 pass_en,
  output logic                 dac_en
);
  localparam int LAST = N_WIN - 1;

  win_t win_q [N_WIN];
  win_t win_d [N_WIN];
  logic pass_q, pass_d, dacen_q, dacen_d;
  logic reg_ce;
  reg_kind_e kind;
  logic [WIN_IDX_W-1:0] idx;
  logic unused_wr_bits;

  assign kind   = reg_kind_e'(wr_sel[3:2]);
  assign idx    = wr_sel[1:0];
  assign reg_ce = wr_en;
  assign unused_wr_bits = ^{wr_data[4:2], wr_data[9:7], wr_data[38:35]};

  always_comb begin
    for (int i = 0; i < N_WIN; i++) win_d[i] = win_q[i];
    pass_d  = pass_q;
    dacen_d = dacen_q;
    unique case (kind)
      KIND_BASE: begin
        win_d[idx].en   = wr_data[0];
        win_d[idx].sg   = (int'(idx) == LAST) ? 1'b1 : wr_data[1];
        win_d[idx].dac  = (int'(idx) == LAST) ? wr_data[DAC_BIT] : 1'b0;
        win_d[idx].base = wr_data[SAC_W-1:WIN_LSB];
      end
      KIND_MASK: win_d[idx].mask = wr_data[SAC_W-1:WIN_LSB];
      KIND_TBA:  win_d[idx].tba  = wr_data[PA_W-1:TBA_LSB];
      KIND_CTL: begin
        pass_d  = wr_data[CTL_PASS_BIT];
        dacen_d = wr_data[CTL_DAC_BIT];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WIN; i++) begin
        win_q[i]    <= '0;
        win_q[i].sg <= (i == LAST);
      end
      pass_q  <= 1'b0;
      dacen_q <= 1'b0;
    end else if (reg_ce) begin
      for (int i = 0; i < N_WIN; i++) win_q[i] <= win_d[i];
      pass_q  <= pass_d;
      dacen_q <= dacen_d;
    end
  end

  always_comb for (int i = 0; i < N_WIN; i++) win[i] = win_q[i];
  assign pass_en = pass_q;
  assign dac_en  = dacen_q;
endmodule

// File: rtl/dwx_window.sv
module dwx_window
  import dwx_pkg::*;
#(
  parameter bit SAC_GATED = 1'b0
) (
  input  win_t              win,
  input  logic [SAC_W-1:0]  addr,
  output xlat_t             res
);
  localparam int IDX_W = SAC_W - PAGE_LSB;

  logic [SAC_W-1:0] span, offset;
  logic [PA_W-1:0]  tba_full;
  logic             match;

  assign span     = {win.mask, {WIN_LSB{1'b1}}};
  assign offset   = addr & span;
  assign tba_full = {win.tba, {TBA_LSB{1'b0}}};
  assign match    = win.en
                  && ((addr[SAC_W-1:WIN_LSB] & ~win.mask) == win.base)
                  && !(SAC_GATED && win.dac);

  always_comb begin
    res = '0;
    if (match) begin
      res.hit = 1'b1;
      res.sg  = win.sg;
      if (win.sg)
        res.pte = tba_full + {{(PA_W-IDX_W-PTE_LSB){1'b0}},
                              offset[SAC_W-1:PAGE_LSB], {PTE_LSB{1'b0}}};
      else
        res.phys = tba_full | {{(PA_W-SAC_W){1'b0}}, offset};
    end
  end
endmodule

// File: rtl/dwx_select.sv
module dwx_select
  import dwx_pkg::*;
(
  input  xlat_t             win_res [N_WIN],
  input  win_t              dac_win,
  input  logic              pass_en,
  input  logic              dac_en,
  input  logic              is_dac,
  input  logic [BUS_W-1:0]  addr,
  output xlat_t             res
);
  localparam int DIDX_W = PA_W - PAGE_LSB;

  logic [PA_W-1:0] dac_base;
  logic unused_addr_bits;

  assign dac_base = {win_res_dummy(dac_win.tba), {DAC_BASE_LSB{1'b0}}};
  assign unused_addr_bits = ^addr[BUS_W-1:PA_W];

  function automatic logic [PA_W-DAC_BASE_LSB-1:0] win_res_dummy(
      input logic [TBA_W-1:0] t);
    return t[TBA_W-1:DAC_BASE_LSB-TBA_LSB];
  endfunction

  always_comb begin
    res = '0;
    if (is_dac) begin
      if (dac_en && dac_win.en && dac_win.dac) begin
        res.hit = 1'b1;
        res.sg  = 1'b1;
        res.pte = dac_base + {{(PA_W-DIDX_W-PTE_LSB){1'b0}},
                              addr[PA_W-1:PAGE_LSB], {PTE_LSB{1'b0}}};
      end
    end else if (pass_en && !addr[SAC_W-1]) begin
      res.hit  = 1'b1;
      res.phys = {{(PA_W-SAC_W+1){1'b0}}, addr[SAC_W-2:0]};
    end else begin
      for (int i = N_WIN - 1; i >= 0; i--)
        if (win_res[i].hit) res = win_res[i];
    end
  end
endmodule

// File: rtl/dma_window_xlat.sv
module dma_window_xlat
  import dwx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic              req_dac,
  input  logic [BUS_W-1:0]  req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_sg,
  output logic [PA_W-1:0]   rsp_phys,
  output logic [PA_W-1:0]   rsp_pte
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  win_t       win [N_WIN];
  logic       pass_en, dac_en;
  xlat_t      win_res [N_WIN];
  xlat_t      sel_res, rsp_d, rsp_q;
  logic       valid_d, valid_q, rsp_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  dwx_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .win(win), .pass_en(pass_en), .dac_en(dac_en)
  );

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    dwx_window #(.SAC_GATED(g == N_WIN - 1)) u_win (
      .win(win[g]), .addr(req_addr[SAC_W-1:0]), .res(win_res[g])
    );
  end

  dwx_select u_sel (
    .win_res(win_res), .dac_win(win[N_WIN-1]), .pass_en(pass_en),
    .dac_en(dac_en), .is_dac(req_dac), .addr(req_addr), .res(sel_res)
  );

  assign rsp_ce  = req_valid | valid_q;
  assign valid_d = req_valid;
  assign rsp_d   = req_valid ? sel_res : '0;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      rsp_q   <= '0;
    end else if (rsp_ce) begin
      valid_q <= valid_d;
      rsp_q   <= rsp_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_hit   = rsp_q.hit;
  assign rsp_sg    = rsp_q.sg;
  assign rsp_phys  = rsp_q.phys;
  assign rsp_pte   = rsp_q.pte;
endmodule

// File: rtl/dwx_checker.sv
module dwx_checker
  import dwx_pkg::*;
(
  input logic            clk,
  input logic            rst_sync_n,
  input logic            req_valid,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_sg,
  input logic [PA_W-1:0] rsp_phys,
  input logic [PA_W-1:0] rsp_pte
);
  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);
  assert_rsp_drops_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);
  assert_miss_zero_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !rsp_hit) |-> (rsp_phys == '0 && rsp_pte == '0 && !rsp_sg));
  assert_direct_no_pte_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_hit && !rsp_sg) |-> (rsp_pte == '0));
  assert_sg_aligned_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_hit && rsp_sg) |-> (rsp_phys == '0 && rsp_pte[PTE_LSB-1:0] == '0));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rsp_valid |-> (!rsp_hit && !rsp_sg));
endmodule

bind dma_window_xlat dwx_checker u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .req_valid(req_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_sg(rsp_sg),
  .rsp_phys(rsp_phys), .rsp_pte(rsp_pte)
);

// File: tb/dma_window_xlat_tb_top.sv
`timescale 1ns/1ps
module dma_window_xlat_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [39:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_dac = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_sg;
  logic [34:0] rsp_phys, rsp_pte;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_window_xlat dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_dac(req_dac), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_sg(rsp_sg),
    .rsp_phys(rsp_phys), .rsp_pte(rsp_pte)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [39:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic xlat(input string req, input logic dac, input logic [63:0] a,
                      input logic hit, input logic sg,
                      input logic [34:0] phys, input logic [34:0] pte);
    @(negedge clk);
    req_valid = 1'b1; req_dac = dac; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check({req, " hit"},   64'(rsp_hit),   64'(hit));
    check({req, " sg"},    64'(rsp_sg),    64'(sg));
    check({req, " phys"},  64'(rsp_phys),  64'(phys));
    check({req, " pte"},   64'(rsp_pte),   64'(pte));
  endtask

  task automatic t_reset;
    check("R1 valid idle", 64'(rsp_valid), 64'd0);
    check("R1 hit idle", 64'(rsp_hit), 64'd0);
    xlat("R1 sac after reset", 1'b0, 64'h0, 1'b0, 1'b0, '0, '0);
    xlat("R1 dac after reset", 1'b1, 64'h1_0000_4000, 1'b0, 1'b0, '0, '0);
    @(negedge clk);
    check("R12 valid drops", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_direct;
    wr(4'h0, 40'hFF_4000_0001 | 40'hFFFFC);
    wr(4'h4, 40'h0010_0000 | 40'hFFFFF);
    wr(4'h8, 40'h1_2340_0000 | 40'h3FF);
    xlat("R2 R4 R6 direct hit", 1'b0, 64'hFFFF_0000_4012_3456, 1'b1, 1'b0, 35'h1_2352_3456, '0);
    xlat("R5 R11 outside window", 1'b0, 64'h4020_0000, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_sg;
    wr(4'h1, 40'h8000_0003);
    wr(4'h5, 40'h0FF0_0000);
    wr(4'h9, 40'h2_0000_0000);
    xlat("R7 sg pte", 1'b0, 64'h8123_6000, 1'b1, 1'b1, '0, 35'h2_0000_48D8);
  endtask

  task automatic t_priority;
    wr(4'h2, 40'h4000_0001);
    wr(4'h6, 40'h0010_0000);
    wr(4'hA, 40'h3_0000_0000);
    xlat("R5 lowest window wins", 1'b0, 64'h4012_3456, 1'b1, 1'b0, 35'h1_2352_3456, '0);
    wr(4'h0, 40'h0);
    xlat("R5 next window", 1'b0, 64'h4012_3456, 1'b1, 1'b0, 35'h3_0012_3456, '0);
  endtask

  task automatic t_last_window;
    wr(4'h3, 40'hC000_0001);
    wr(4'h7, 40'h0);
    wr(4'hB, 40'h4_0000_0000);
    xlat("R3 R8 forced sg", 1'b0, 64'hC000_2000, 1'b1, 1'b1, '0, 35'h4_0000_0008);
    wr(4'h3, 40'h80_C000_0001);
    xlat("R8 dac bit hides window", 1'b0, 64'hC000_2000, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_dac;
    xlat("R9 control off", 1'b1, 64'h1_0000_4000, 1'b0, 1'b0, '0, '0);
    wr(4'hB, 40'h4_0010_0400);
    wr(4'hC, 40'hDF);
    xlat("R9 dac pte", 1'b1, 64'h1_0000_4000, 1'b1, 1'b1, '0, 35'h4_0040_0010);
    xlat("R13 pass bit not set", 1'b0, 64'h4012_3456, 1'b1, 1'b0, 35'h3_0012_3456, '0);
    wr(4'h3, 40'h80_0000_0000);
    xlat("R9 window disabled", 1'b1, 64'h1_0000_4000, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_pass;
    wr(4'hC, 40'h20);
    xlat("R10 pass first", 1'b0, 64'h4012_3456, 1'b1, 1'b0, 35'h0_4012_3456, '0);
    xlat("R10 high half to window", 1'b0, 64'h8123_6000, 1'b1, 1'b1, '0, 35'h2_0000_48D8);
    xlat("R13 dac control cleared", 1'b1, 64'h1_0000_4000, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    req_valid = 1'b1; req_dac = 1'b0; req_addr = 64'h8123_6000;
    wr_en = 1'b1; wr_sel = 4'h1; wr_data = 40'h0;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    check("R12 old mapping hit", 64'(rsp_hit), 64'd1);
    check("R12 old mapping pte", 64'(rsp_pte), 64'h2_0000_48D8);
    xlat("R12 new mapping", 1'b0, 64'h8123_6000, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_direct();
    t_sg();
    t_priority();
    t_last_window();
    t_dac();
    t_pass();
    t_same_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule